// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block turns a 128-bit plaintext block into its AES-128 ciphertext. A single round unit (byte substitution, row rotation, column mixing and key addition) is instantiated once and reused over ten clocked iterations. The final pass bypasses the column mix. The forward S-box is built inside the block as GF(2^8) inversion followed by the affine map, so no lookup table is stored.

The block does not expand keys. It publishes a round index, and an external key schedule answers combinationally on the round-key input with the matching 128-bit round key. A caller pulses `start` with the plaintext present. Eleven cycles later `done` pulses for one cycle, and `ciphertext` then holds the result until the next accepted start.

Top module: `aes_iter_enc`

## Requirements
- R1: While reset is held and after it is released, `done` is low and `rk_idx` is 0, until a start is accepted.
- R2: A start sampled while the block is idle is accepted. On the clock edges that follow, `rk_idx` reads 0, then 1 through 10, one step per cycle, and it returns to 0 when `done` rises.
- R3: On the first cycle after acceptance, the state becomes the plaintext XOR round key 0.
- R4: Byte k of the state is bits [127-8k -: 8] of a 128-bit word. The state is column-major: byte k sits in row k mod 4 and column k div 4.
- R5: Each of the 16 bytes is substituted through one S-box. The S-box is the multiplicative inverse modulo 0x11B (with 0 mapping to 0), followed by the affine map with constant 0x63.
- R6: Row r of the state rotates left by r byte positions. Row 0 does not move.
- R7: Rounds 1 to 9 multiply each column by the circulant matrix of {02,03,01,01} over GF(2^8) modulo 0x11B. Round 10 leaves out this step.
- R8: `done` is high for exactly one cycle, 11 clock cycles after the edge that accepted start.
- R9: A start asserted while a block is in flight has no effect on the index sequence, on the timing or on the result.
- R10: Once `done` has risen, `ciphertext` keeps its value until the next accepted start, whatever `plaintext` does.
- R11: With key 000102..0f and plaintext 00112233..ff, the ciphertext is 69c4e0d86a7b0430d8cdb78070b4c55a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin encrypting `plaintext`, taken only when idle |
| plaintext | input | 128 | Input block, byte 0 in the top bits |
| rk_idx | output | 4 | Round index presented to the key schedule |
| rk_data | input | 128 | Round key for `rk_idx`, supplied combinationally |
| ciphertext | output | 128 | Encrypted block, valid from `done` on |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `rk_data` is a pure function of `rk_idx`, settled within the same cycle, and that `start` is a clean synchronous level. They check only sequencing and output stability, never the ciphertext value. The bench meets these assumptions with a key schedule model that indexes a precomputed round-key array by `rk_idx`. It drives `start` and `plaintext` only at falling edges. The arithmetic is checked against a bench reference model built on log/antilog tables, which is a different construction from the RTL's inversion logic.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

  localparam int BLK_W  = 128;
  localparam int BYTE_W = 8;
  localparam int NBYTES = BLK_W / BYTE_W;

  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t gf_dbl(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_enc_pkg::*;
(
  input  logic [7:0] din,
  output logic [7:0] dout
);

  byte_t inv;
  byte_t pw;

  always_comb begin
    pw  = din;
    inv = 8'h01;
    for (int i = 0; i < 7; i++) begin
      pw  = gf_mul(pw, pw);
      inv = gf_mul(inv, pw);
    end
  end

  assign dout = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;

endmodule

// File: rtl/aes_mixcol.sv
module aes_mixcol
  import aes_enc_pkg::*;
(
  input  logic [31:0] col_in,
  output logic [31:0] col_out
);

  byte_t a [4];
  byte_t d [4];

  always_comb begin
    for (int r = 0; r < 4; r++) begin
      a[r] = col_in[31-8*r -: 8];
      d[r] = gf_dbl(a[r]);
    end
  end

  assign col_out[31:24] = d[0] ^ d[1] ^ a[1] ^ a[2] ^ a[3];
  assign col_out[23:16] = a[0] ^ d[1] ^ d[2] ^ a[2] ^ a[3];
  assign col_out[15:8]  = a[0] ^ a[1] ^ d[2] ^ d[3] ^ a[3];
  assign col_out[7:0]   = d[0] ^ a[0] ^ a[1] ^ a[2] ^ d[3];

endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_enc_pkg::*;
(
  input  logic [127:0] st_in,
  input  logic [127:0] rkey,
  input  logic         last,
  output logic [127:0] st_out
);

  logic [127:0] subd;
  logic [127:0] shft;
  logic [127:0] mixd;

  for (genvar k = 0; k < NBYTES; k++) begin : g_sub
    aes_sbox sbox_i (
      .din  (st_in[BLK_W-1-BYTE_W*k -: BYTE_W]),
      .dout (subd[BLK_W-1-BYTE_W*k -: BYTE_W])
    );
  end

  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int DST = r + 4 * c;
      localparam int SRC = r + 4 * ((c + r) % 4);
      assign shft[BLK_W-1-BYTE_W*DST -: BYTE_W] = subd[BLK_W-1-BYTE_W*SRC -: BYTE_W];
    end
    aes_mixcol mix_i (
      .col_in  (shft[BLK_W-1-32*c -: 32]),
      .col_out (mixd[BLK_W-1-32*c -: 32])
    );
  end

  assign st_out = (last ? shft : mixd) ^ rkey;

endmodule

// File: rtl/aes_iter_enc.sv
module aes_iter_enc
  import aes_enc_pkg::*;
#(
  parameter int NROUNDS = 10,
  localparam int RIDX_W = $clog2(NROUNDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [127:0]      plaintext,
  output logic [RIDX_W-1:0] rk_idx,
  input  logic [127:0]      rk_data,
  output logic [127:0]      ciphertext,
  output logic              done
);

  localparam logic [RIDX_W-1:0] LAST_RND = RIDX_W'(NROUNDS);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              busy_q, busy_d;
  logic [RIDX_W-1:0] rnd_q, rnd_d;
  logic              done_q, done_d;
  blk_t              st_q, st_d;
  logic              st_en;
  logic              accept;
  blk_t              round_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  aes_round round_i (
    .st_in  (st_q),
    .rkey   (rk_data),
    .last   (rnd_q == LAST_RND),
    .st_out (round_out)
  );

  assign accept = start & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    rnd_d  = rnd_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      rnd_d  = '0;
    end else if (busy_q) begin
      if (rnd_q == LAST_RND) begin
        busy_d = 1'b0;
        rnd_d  = '0;
        done_d = 1'b1;
      end else begin
        rnd_d = rnd_q + RIDX_W'(1);
      end
    end
  end

  always_comb begin
    st_en = accept | busy_q;
    if (accept)            st_d = plaintext;
    else if (rnd_q == '0)  st_d = st_q ^ rk_data;
    else                   st_d = round_out;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      rnd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rnd_q  <= rnd_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  st_q <= '0;
    else if (st_en)  st_q <= st_d;
  end

  assign rk_idx     = rnd_q;
  assign ciphertext = st_q;
  assign done       = done_q;

endmodule

// File: rtl/aes_iter_enc_chk.sv
module aes_iter_enc_chk #(
  parameter int NROUNDS = 10,
  localparam int RIDX_W = $clog2(NROUNDS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy_q,
  input logic [RIDX_W-1:0] rk_idx,
  input logic [127:0]      ciphertext,
  input logic              done
);

  localparam logic [RIDX_W-1:0] LAST_RND = RIDX_W'(NROUNDS);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rk_idx == LAST_RND) |=> done); // R8

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rk_idx != LAST_RND) |=> (busy_q && rk_idx == $past(rk_idx) + RIDX_W'(1))); // R2

  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> rk_idx == '0); // R2

  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !done) |=> !done); // R1

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rk_idx != LAST_RND && start) |=> busy_q); // R9

  AST_CT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(ciphertext)); // R10

endmodule

bind aes_iter_enc aes_iter_enc_chk #(.NROUNDS(NROUNDS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy_q     (busy_q),
  .rk_idx     (rk_idx),
  .ciphertext (ciphertext),
  .done       (done)
);

// File: tb/aes_iter_enc_tb.sv
module aes_iter_enc_tb_top;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [127:0] plaintext;
  logic [3:0]   rk_idx;
  logic [127:0] rk_data;
  logic [127:0] ciphertext;
  logic         done;

  int n_checks;
  int n_errors;

  logic [127:0] rk_tab [0:10];
  logic [7:0]   exp_t  [0:255];
  logic [7:0]   log_t  [0:255];
  logic [7:0]   sb_t   [0:255];

  aes_iter_enc dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .plaintext  (plaintext),
    .rk_idx     (rk_idx),
    .rk_data    (rk_data),
    .ciphertext (ciphertext),
    .done       (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign rk_data = (rk_idx <= 4'd10) ? rk_tab[rk_idx] : 128'h0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return exp_t[(int'(log_t[a]) + int'(log_t[b])) % 255];
  endfunction

  task automatic build_tables();
    logic [7:0] x;
    logic [7:0] v;
    logic [7:0] s;
    x = 8'h01;
    for (int i = 0; i < 256; i++) log_t[i] = 8'h00;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = x;
      log_t[x] = 8'(i);
      x = x ^ {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    exp_t[255] = exp_t[0];
    for (int i = 0; i < 256; i++) begin
      v = (i == 0) ? 8'h00 : exp_t[(255 - int'(log_t[i])) % 255];
      for (int b = 0; b < 8; b++)
        s[b] = v[b] ^ v[(b+4)%8] ^ v[(b+5)%8] ^ v[(b+6)%8] ^ v[(b+7)%8] ^ ((8'h63 >> b) & 8'h01) != 0;
      sb_t[i] = s;
    end
  endtask

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [0:43];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb_t[t[23:16]], sb_t[t[15:8]], sb_t[t[7:0]], sb_t[t[31:24]]} ^ {rc, 24'h0};
        rc = tmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk_tab[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [7:0] s [16];
    logic [7:0] u [16];
    logic [127:0] blk;
    blk = pt ^ rk_tab[0];
    for (int r = 1; r <= 10; r++) begin
      for (int k = 0; k < 16; k++) s[k] = sb_t[blk[127-8*k -: 8]];
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) u[w+4*c] = s[w + 4*((c+w)%4)];
      if (r < 10) begin
        for (int c = 0; c < 4; c++)
          for (int w = 0; w < 4; w++)
            s[w+4*c] = tmul(8'h02, u[4*c+w]) ^ tmul(8'h03, u[4*c+(w+1)%4])
                     ^ u[4*c+(w+2)%4] ^ u[4*c+(w+3)%4];
      end else begin
        for (int k = 0; k < 16; k++) s[k] = u[k];
      end
      for (int k = 0; k < 16; k++) blk[127-8*k -: 8] = s[k];
      blk = blk ^ rk_tab[r];
    end
    return blk;
  endfunction

  task automatic run_one(input logic [127:0] pt, input logic [127:0] key,
                         input bit glitch, input logic [127:0] other, input string tag);
    logic [127:0] exp_ct;
    logic [127:0] held;
    bit idx_ok;
    bit done_ok;
    bit still;
    expand(key);
    exp_ct = ref_enc(pt);
    idx_ok = 1'b1;
    done_ok = 1'b1;
    @(negedge clk);
    start = 1'b1;
    plaintext = pt;
    for (int k = 0; k <= 11; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (glitch && k == 3) begin start = 1'b1; plaintext = other; end
      if (glitch && k == 4) start = 1'b0;
      if (rk_idx != ((k <= 10) ? 4'(k) : 4'd0)) idx_ok = 1'b0;
      if (done != (k == 11)) done_ok = 1'b0;
    end
    chk(idx_ok, {"R2 index sequence ", tag}, {124'h0, rk_idx}, 128'h0);
    chk(done_ok, {"R8 done timing ", tag}, {127'h0, done}, 128'h1);
    // R3 R4 R5 R6 R7: full-round arithmetic against the reference model
    chk(ciphertext === exp_ct, {"R3 R4 R5 R6 R7 ciphertext ", tag}, ciphertext, exp_ct);
    if (glitch) chk(ciphertext === exp_ct, {"R9 start while busy ", tag}, ciphertext, exp_ct);
    held = ciphertext;
    still = 1'b1;
    for (int k = 0; k < 3; k++) begin
      plaintext = {$urandom, $urandom, $urandom, $urandom};
      @(posedge clk);
      @(negedge clk);
      if (done !== 1'b0 || ciphertext !== held) still = 1'b0;
    end
    chk(still, {"R8 R10 pulse end and hold ", tag}, ciphertext, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [127:0] fips_ct;
    n_checks = 0;
    n_errors = 0;
    rst_n = 1'b0;
    start = 1'b0;
    plaintext = '0;
    build_tables();
    for (int r = 0; r < 11; r++) rk_tab[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0 && rk_idx === 4'd0, "R1 during reset", {123'h0, done, rk_idx}, 128'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done === 1'b0 && rk_idx === 4'd0, "R1 after reset", {123'h0, done, rk_idx}, 128'h0);

    // R11: standard example vector
    fips_ct = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    expand(128'h000102030405060708090a0b0c0d0e0f);
    chk(ref_enc(128'h00112233445566778899aabbccddeeff) === fips_ct, "R11 bench model",
        ref_enc(128'h00112233445566778899aabbccddeeff), fips_ct);
    run_one(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
            1'b0, '0, "vector");
    chk(ciphertext === fips_ct, "R11 known answer", ciphertext, fips_ct);

    // edge patterns: zero and all-ones blocks and keys
    run_one('0, '0, 1'b0, '0, "zeros");
    run_one('1, '1, 1'b0, '0, "ones");
    run_one('0, '1, 1'b0, '0, "zero-pt");
    // R9: second start mid-flight must be ignored
    run_one(128'h0123456789abcdeffedcba9876543210, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0,
            1'b1, 128'hdeadbeefdeadbeefdeadbeefdeadbeef, "glitch");
    // sweep of pseudo-random blocks and keys
    for (int n = 0; n < 40; n++)
      run_one({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
              (n % 5) == 0, {$urandom, $urandom, $urandom, $urandom}, "sweep");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule